// File: doc/BRIEF.md
# Display Engine Run/Stop and Configuration Update Controller

This block is the global sequencing and interrupt logic of a display engine. Software writes a small register port. It uses that port to start the engine, stop it, request a configuration update, stage a pending configuration word, program the interrupt enables and clear interrupt status. The block holds two copies of the configuration word. The pending copy is the one software writes. The active copy is the one the pixel pipeline uses. The block decides the exact cycle in which the pending copy becomes active.

Two operating styles are selected by `cmd_mode`. In continuous video operation the engine keeps running, and a new configuration takes effect only at a frame boundary after an explicit update request. In command operation there is no staging between frames. Each start captures the pending word and sends exactly one frame. The start bit then clears itself at frame end.

Hardware events set interrupt status bits whether or not they are enabled. The interrupt line is the OR of the enabled status bits.

Top module: `dctl_top`

## Requirements
- R1: After reset, `busy` is 0, `active_cfg` is 0, `irq_status` is 0, every interrupt enable is 0 and `irq` is 0.
- R2: The register port uses a write strobe, an address and data. Address 0 is control, with bit 0 = start, bit 1 = stop and bit 2 = update request; each bit acts only in the cycle it is written. Address 1 loads the pending configuration from the low data bits. Address 2 loads the interrupt enable mask. Address 3 is the write-one-to-clear port for status. Status bit positions are: 0 = done, 1 = tearing effect, 2 = underflow, 4 = update done, 5 = vsync; bits 3, 6 and 7 always read 0.
- R3: In video mode (`cmd_mode`=0), a start write while idle sets `busy` and loads the pending word into `active_cfg` on the same clock edge.
- R4: In video mode, an update request while busy is held until the next `frame_end`. On that edge `active_cfg` takes the pending word and status bit 4 sets. Before that edge, `active_cfg` does not change.
- R5: Nothing happens for an update request made while idle, or made in command mode. Writing the pending word without an update request also leaves `active_cfg` unchanged in video mode.
- R6: In video mode, a stop write while busy takes effect at the next `frame_end`. `busy` drops and status bit 0 sets on that edge. Every `frame_end` seen while busy in video mode sets status bit 5.
- R7: In command mode (`cmd_mode`=1), a start write while idle captures the pending word into `active_cfg` and sets `busy`. While busy, `active_cfg` does not change, and a further start write has no effect.
- R8: In command mode, `frame_end` while busy clears `busy` and sets status bit 0 but not bit 5. A later start write begins a new frame with a fresh capture.
- R9: `te_pulse` sets status bit 1 and `underflow` sets status bit 2, whatever the enable mask holds.
- R10: A write of ones to address 3 clears those status bits, and 0xFF clears all of them. If an event and a clear hit the same bit in the same cycle, the event wins.
- R11: `irq` is 1 exactly when some status bit is set and its enable bit is set. It follows both registers with no further delay.
- R12: A `frame_end` while idle sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mode | input | 1 | 0 = continuous video, 1 = one frame per start; change only while idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| frame_end | input | 1 | One-cycle end-of-frame strobe from the pipeline |
| te_pulse | input | 1 | One-cycle tearing-effect strobe |
| underflow | input | 1 | One-cycle pixel underflow strobe |
| active_cfg | output | CFG_W | Configuration word in use by the pipeline |
| busy | output | 1 | Engine is running a frame or frames |
| irq | output | 1 | Interrupt request |
| irq_status | output | 8 | Interrupt status register |

## Verification
The bench builds the block with a 12-bit configuration word and 16-bit write data. The configuration is narrower than the data path, so high data bits are present but must be ignored. Twelve bits are still enough for distinct patterns to tell the old, pending and newly written words apart at each promotion point. The 2-bit address reaches all four registers. With this build the bench can reach the same-edge cases: a clear racing an event, a start written while busy, and update or stop requests that must wait for the next frame end.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  localparam int INT_W    = 8;
  localparam int IB_DONE  = 0;
  localparam int IB_TE    = 1;
  localparam int IB_UFLOW = 2;
  localparam int IB_UPD   = 4;
  localparam int IB_VSYNC = 5;
  localparam int CB_RUN   = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_UPD   = 2;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_PEND   = 2'd1,
    RA_INTEN  = 2'd2,
    RA_INTCLR = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic run;
    logic stop;
    logic upd;
  } ctl_req_t;
endpackage

// File: rtl/dctl_wr_decode.sv
module dctl_wr_decode
  import dctl_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_req_t          req,
  output logic [CFG_W-1:0]  pend_cfg,
  output logic [INT_W-1:0]  int_en,
  output logic [INT_W-1:0]  int_clr
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(RA_PEND);
  localparam logic [ADDR_W-1:0] A_INTEN  = ADDR_W'(RA_INTEN);
  localparam logic [ADDR_W-1:0] A_INTCLR = ADDR_W'(RA_INTCLR);

  logic             sel_ctrl, sel_pend, sel_inten, sel_intclr;
  logic [CFG_W-1:0] pend_q, pend_d;
  logic [INT_W-1:0] en_q, en_d;

  always_comb begin
    sel_ctrl   = wr_en && (wr_addr == A_CTRL);
    sel_pend   = wr_en && (wr_addr == A_PEND);
    sel_inten  = wr_en && (wr_addr == A_INTEN);
    sel_intclr = wr_en && (wr_addr == A_INTCLR);
    req.run    = sel_ctrl && wr_data[CB_RUN];
    req.stop   = sel_ctrl && wr_data[CB_STOP];
    req.upd    = sel_ctrl && wr_data[CB_UPD];
    int_clr    = sel_intclr ? wr_data[INT_W-1:0] : '0;
    pend_d     = sel_pend  ? wr_data[CFG_W-1:0] : pend_q;
    en_d       = sel_inten ? wr_data[INT_W-1:0] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (sel_pend)  pend_q <= pend_d;
      if (sel_inten) en_q   <= en_d;
    end
  end

  assign pend_cfg = pend_q;
  assign int_en   = en_q;
endmodule

// File: rtl/dctl_seq.sv
module dctl_seq
  import dctl_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_mode,
  input  ctl_req_t         req,
  input  logic [CFG_W-1:0] pend_cfg,
  input  logic             frame_end,
  output logic             busy,
  output logic [CFG_W-1:0] active_cfg,
  output logic             ev_done,
  output logic             ev_upd,
  output logic             ev_vsync
);
  logic             busy_q, busy_d;
  logic             stop_q, stop_d;
  logic             upd_q, upd_d;
  logic [CFG_W-1:0] act_q, act_d;
  logic             act_ld;

  always_comb begin
    busy_d   = busy_q;
    stop_d   = stop_q;
    upd_d    = upd_q;
    act_d    = act_q;
    act_ld   = 1'b0;
    ev_done  = 1'b0;
    ev_upd   = 1'b0;
    ev_vsync = 1'b0;
    if (cmd_mode) begin
      // single-frame operation: no staging, capture on start only
      stop_d = 1'b0;
      upd_d  = 1'b0;
      if (busy_q) begin
        if (frame_end) begin
          busy_d  = 1'b0;
          ev_done = 1'b1;
        end
      end else if (req.run) begin
        busy_d = 1'b1;
        act_d  = pend_cfg;
        act_ld = 1'b1;
      end
    end else begin
      if (busy_q) begin
        if (req.upd)  upd_d  = 1'b1;
        if (req.stop) stop_d = 1'b1;
        if (frame_end) begin
          ev_vsync = 1'b1;
          upd_d    = req.upd;
          stop_d   = req.stop;
          if (upd_q) begin
            act_d  = pend_cfg;
            act_ld = 1'b1;
            ev_upd = 1'b1;
          end
          if (stop_q) begin
            busy_d  = 1'b0;
            ev_done = 1'b1;
            upd_d   = 1'b0;
            stop_d  = 1'b0;
          end
        end
      end else begin
        upd_d  = 1'b0;
        stop_d = 1'b0;
        if (req.run) begin
          busy_d = 1'b1;
          act_d  = pend_cfg;
          act_ld = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      stop_q <= 1'b0;
      upd_q  <= 1'b0;
      act_q  <= '0;
    end else begin
      busy_q <= busy_d;
      stop_q <= stop_d;
      upd_q  <= upd_d;
      if (act_ld) act_q <= act_d;
    end
  end

  assign busy       = busy_q;
  assign active_cfg = act_q;
endmodule

// File: rtl/dctl_irq.sv
module dctl_irq
  import dctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] ev,
  input  logic [INT_W-1:0] int_clr,
  input  logic [INT_W-1:0] int_en,
  output logic [INT_W-1:0] status,
  output logic             irq
);
  logic [INT_W-1:0] sts_q, sts_d;
  logic             sts_ce;

  always_comb begin
    sts_d  = (sts_q & ~int_clr) | ev;
    sts_ce = (|ev) || (|int_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  assign status = sts_q;
  assign irq    = |(sts_q & int_en);
endmodule

// File: rtl/dctl_top.sv
module dctl_top
  import dctl_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_end,
  input  logic              te_pulse,
  input  logic              underflow,
  output logic [CFG_W-1:0]  active_cfg,
  output logic              busy,
  output logic              irq,
  output logic [7:0]        irq_status
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ctl_req_t         req_w;
  logic [CFG_W-1:0] pend_cfg_w;
  logic [INT_W-1:0] int_en_w, int_clr_w, ev_w, sts_w;
  logic             done_w, upd_w, vsync_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dctl_wr_decode #(.CFG_W(CFG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req_w), .pend_cfg(pend_cfg_w),
    .int_en(int_en_w), .int_clr(int_clr_w)
  );

  dctl_seq #(.CFG_W(CFG_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .cmd_mode(cmd_mode), .req(req_w),
    .pend_cfg(pend_cfg_w), .frame_end(frame_end), .busy(busy),
    .active_cfg(active_cfg), .ev_done(done_w), .ev_upd(upd_w),
    .ev_vsync(vsync_w)
  );

  always_comb begin
    ev_w           = '0;
    ev_w[IB_DONE]  = done_w;
    ev_w[IB_TE]    = te_pulse;
    ev_w[IB_UFLOW] = underflow;
    ev_w[IB_UPD]   = upd_w;
    ev_w[IB_VSYNC] = vsync_w;
  end

  dctl_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .ev(ev_w), .int_clr(int_clr_w),
    .int_en(int_en_w), .status(sts_w), .irq(irq)
  );

  assign irq_status = sts_w;
endmodule

// File: rtl/dctl_chk.sv
module dctl_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_mode,
  input logic             frame_end,
  input logic             busy,
  input logic             irq,
  input logic [7:0]       irq_status,
  input logic [CFG_W-1:0] active_cfg,
  input logic [CFG_W-1:0] pend_cfg
);
  AST_VID_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_mode && $rose(busy)) |-> (active_cfg == $past(pend_cfg))); // R3
  AST_VID_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_mode && busy && !frame_end) |=> $stable(active_cfg)); // R4
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[0]) |-> !busy); // R6
  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && $rose(busy)) |-> (active_cfg == $past(pend_cfg))); // R7
  AST_CMD_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && busy && !frame_end) |=> (busy && $stable(active_cfg))); // R7
  AST_CMD_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && frame_end) |=> !$rose(irq_status[5])); // R8
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_status != 8'h00)); // R11
  AST_IDLE_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_end) |=> (!$rose(irq_status[0]) && !$rose(irq_status[5]))); // R12
endmodule

bind dctl_top dctl_chk #(.CFG_W(CFG_W)) u_dctl_chk (
  .clk(clk), .rst_n(rst_int_n), .cmd_mode(cmd_mode), .frame_end(frame_end),
  .busy(busy), .irq(irq), .irq_status(irq_status), .active_cfg(active_cfg),
  .pend_cfg(pend_cfg_w)
);

// File: tb/dctl_top_bench.sv
`timescale 1ns/1ps
module dctl_top_bench;
  localparam int CFG_W  = 12;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  logic              clk;
  logic              rst_n;
  logic              cmd_mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              frame_end, te_pulse, underflow;
  logic [CFG_W-1:0]  active_cfg;
  logic              busy, irq;
  logic [7:0]        irq_status;

  int checks = 0;
  int errors = 0;

  dctl_top #(.CFG_W(CFG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dctl_top (
    .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_end(frame_end),
    .te_pulse(te_pulse), .underflow(underflow), .active_cfg(active_cfg),
    .busy(busy), .irq(irq), .irq_status(irq_status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fe_pulse();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic clr_all();
    wr(2'd3, 16'h00FF);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 active_cfg", 32'(active_cfg), 0);
    chk("R1 status", 32'(irq_status), 0);
    chk("R1 irq", 32'(irq), 0);
    te_pulse = 1'b1; @(negedge clk); te_pulse = 1'b0; @(negedge clk);
    chk("R1 enables zero, irq masked", 32'(irq), 0);
    clr_all();
  endtask

  task automatic t_video_start();
    cmd_mode = 1'b0;
    wr(2'd1, 16'hFA5C);  // high bits beyond CFG_W dropped
    chk("R2 pending not active yet", 32'(active_cfg), 0);
    wr(2'd0, 16'h0001);
    chk("R3 start loads pending", 32'(active_cfg), 32'hA5C);
    chk("R3 busy set", 32'(busy), 1);
    chk("R3 no status", 32'(irq_status), 0);
  endtask

  task automatic t_video_update();
    wr(2'd1, 16'h03F1);
    wr(2'd0, 16'h0004);
    repeat (3) @(negedge clk);
    chk("R4 held before frame end", 32'(active_cfg), 32'hA5C);
    chk("R4 no update-done yet", 32'(irq_status[4]), 0);
    fe_pulse();
    chk("R4 promoted at frame end", 32'(active_cfg), 32'h3F1);
    chk("R4 update-done and R6 vsync", 32'(irq_status), 32'h30);
    clr_all();
    chk("R10 clear all", 32'(irq_status), 0);
  endtask

  task automatic t_video_ignored();
    wr(2'd1, 16'h0111);
    fe_pulse();
    chk("R5 write without update ignored", 32'(active_cfg), 32'h3F1);
    chk("R5 only vsync", 32'(irq_status), 32'h20);
    clr_all();
  endtask

  task automatic t_video_stop();
    wr(2'd0, 16'h0002);
    chk("R6 busy until frame end", 32'(busy), 1);
    fe_pulse();
    chk("R6 stopped", 32'(busy), 0);
    chk("R6 done and vsync", 32'(irq_status), 32'h21);
    clr_all();
    fe_pulse();
    chk("R12 idle frame end quiet", 32'(irq_status), 0);
    wr(2'd0, 16'h0004);
    fe_pulse();
    chk("R5 idle update ignored cfg", 32'(active_cfg), 32'h3F1);
    chk("R5 idle update no status", 32'(irq_status), 0);
  endtask

  task automatic t_irq();
    @(negedge clk); te_pulse = 1'b1; @(negedge clk); te_pulse = 1'b0;
    chk("R9 te sets bit1 while masked", 32'(irq_status), 32'h02);
    chk("R11 masked no irq", 32'(irq), 0);
    wr(2'd2, 16'h0002);
    chk("R11 enable raises irq", 32'(irq), 1);
    @(negedge clk); underflow = 1'b1; @(negedge clk); underflow = 1'b0;
    chk("R9 underflow bit2", 32'(irq_status), 32'h06);
    wr(2'd3, 16'h0002);
    chk("R10 selective clear", 32'(irq_status), 32'h04);
    chk("R11 irq drops", 32'(irq), 0);
    wr(2'd2, 16'h0004);
    chk("R11 irq on bit2", 32'(irq), 1);
    clr_all();
    chk("R10 clear 0xFF", 32'(irq_status), 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0002; te_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; te_pulse = 1'b0;
    chk("R10 event wins over clear", 32'(irq_status), 32'h02);
    wr(2'd2, 16'h0000);
    clr_all();
  endtask

  task automatic t_cmd();
    cmd_mode = 1'b1;
    wr(2'd1, 16'h00C3);
    wr(2'd0, 16'h0001);
    chk("R7 start captures", 32'(active_cfg), 32'h0C3);
    chk("R7 busy", 32'(busy), 1);
    wr(2'd1, 16'h0777);
    wr(2'd0, 16'h0001);
    chk("R7 start while busy ignored", 32'(active_cfg), 32'h0C3);
    wr(2'd0, 16'h0004);
    chk("R5 cmd update ignored", 32'(active_cfg), 32'h0C3);
    fe_pulse();
    chk("R8 run self-clears", 32'(busy), 0);
    chk("R8 done only, no vsync or update", 32'(irq_status), 32'h01);
    clr_all();
    wr(2'd0, 16'h0001);
    chk("R8 new frame fresh capture", 32'(active_cfg), 32'h777);
    fe_pulse();
    chk("R8 second frame done", 32'(irq_status), 32'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_mode = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    frame_end = 1'b0; te_pulse = 1'b0; underflow = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_video_start();
    t_video_update();
    t_video_ignored();
    t_video_stop();
    t_irq();
    t_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule